// File: doc/BRIEF.md
# External Parallel SRAM Bus Sequencer

This block sits between a small processor core and an external asynchronous SRAM. When the core issues a load or a store, the block runs one bus cycle and then returns. On that bus the low address byte and the data share one 8-bit port. The high address byte has its own 8-bit port. An address latch on the board captures the low byte when the address strobe falls. The read and write strobes are active low.

Every cycle opens with a single address period. In that period the address strobe is high and the low address byte is on the shared port. A strobe phase follows and lasts one period plus zero to three wait periods. A final hold period ends the cycle, and the core sees ready only in that period. The wait count comes from a 2-bit setting. There is one setting for the upper address sector and another for the lower sector. An upper-byte threshold divides the two sectors.

A bus keeper can be enabled. When it is on, the shared port keeps driving the last data value between cycles. When it is off, the port is released.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `memAleO` is 0, `memRdNO` and `memWrNO` are 1, `coreReadyO` is 0, `memAddrHiO` is 0 and `memAdOeO` is 0 (keeper off).
- R2: In the first period after an accepted request, `memAleO` is 1 for exactly one period. In that period `memAdOeO` is 1, `memAdO` carries address bits [7:0] and `memAddrHiO` carries bits [15:8].
- R3: A request whose address bits [15:8] are greater than or equal to `cfgSectorLimitI` uses `cfgWaitHighI`. Any other request uses `cfgWaitLowI`.
- R4: A 2-bit wait setting w (00, 01, 10, 11 meaning 0 to 3) gives a strobe phase of 1+w periods and a whole cycle of 3+w periods.
- R5: In a write, `memWrNO` is 0 throughout the strobe phase. `memAdOeO` is 1 and `memAdO` carries the write data from the strobe phase through the final period.
- R6: In a read, `memRdNO` is 0 throughout the strobe phase and `memAdOeO` is 0. The shared port is sampled at the last strobe period. The sampled value appears on `coreRdataO` together with ready.
- R7: `memRdNO` and `memWrNO` are never 0 together, and neither is 0 while `memAleO` is 1.
- R8: `coreReadyO` is 1 for exactly one period, the final one, which directly follows the strobe phase.
- R9: `memAleO` is 1 only in the address period of an accepted request. While idle it stays 0.
- R10: `memAddrHiO` keeps the previous cycle's high address byte until the next address period.
- R11: While idle, a 1 on `cfgKeeperI` makes `memAdOeO` 1 with `memAdO` showing the last write or read data. A 0 leaves `memAdOeO` at 0.
- R12: A change to the wait settings after a request has been accepted does not alter that cycle's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreValidI | input | 1 | Core requests an access (held until ready) |
| coreWriteI | input | 1 | 1 = store, 0 = load |
| coreAddrI | input | 16 | Target address |
| coreWdataI | input | 8 | Store data |
| coreReadyO | output | 1 | Final period of the cycle; access complete |
| coreRdataO | output | 8 | Load data, valid with ready |
| cfgSectorLimitI | input | 8 | First high-byte value of the upper sector |
| cfgWaitLowI | input | 2 | Wait setting, lower sector |
| cfgWaitHighI | input | 2 | Wait setting, upper sector |
| cfgKeeperI | input | 1 | Bus keeper enable |
| memAleO | output | 1 | Address latch enable |
| memRdNO | output | 1 | Read strobe, active low |
| memWrNO | output | 1 | Write strobe, active low |
| memAddrHiO | output | 8 | High address byte |
| memAdO | output | 8 | Shared port output value |
| memAdOeO | output | 1 | Shared port output enable |
| memAdI | input | 8 | Shared port input value |

## Verification
The checker watches several properties on every cycle. The two strobes must never overlap, and neither may be active during the address period. The address strobe must be a single-period pulse that leads straight into a strobe. Ready must be a single period that directly follows a strobe. The high address byte may change only with the address strobe. Whichever strobe is active must agree with the shared port direction. The bench scenarios cover the properties that depend on values. These are the exact cycle length for each wait setting, the choice of sector at the threshold and just below it, and the data returned on a load. They also cover what the keeper holds between cycles and whether a mid-cycle change to the settings is ignored.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ADDR   = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_FINAL  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic accept;     // capture the request this edge
    logic addrPhase;  // address latch period
    logic strbPhase;  // RD/WR active period
    logic finalPhase; // hold period with ready
    logic capture;    // sample shared port at this edge
    logic idle;
  } seqCtl_t;

endpackage

// File: rtl/xmem_seq_ctrl.sv
module xmem_seq_ctrl
  import xmem_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              curWrite,
  input  logic [WAIT_W-1:0] curWait,
  output seqCtl_t           ctl
);

  seqState_t        state, stateNext;
  logic [WAIT_W-1:0] waitCnt, waitCntNext;

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    unique case (state)
      SEQ_IDLE: begin
        if (reqValid) stateNext = SEQ_ADDR;
      end
      SEQ_ADDR: begin
        stateNext   = SEQ_STROBE;
        waitCntNext = curWait;
      end
      SEQ_STROBE: begin
        if (waitCnt == '0) stateNext = SEQ_FINAL;
        else               waitCntNext = waitCnt - 1'b1;
      end
      SEQ_FINAL: begin
        stateNext = SEQ_IDLE;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.idle       = (state == SEQ_IDLE);
    ctl.accept     = (state == SEQ_IDLE) && reqValid;
    ctl.addrPhase  = (state == SEQ_ADDR);
    ctl.strbPhase  = (state == SEQ_STROBE);
    ctl.finalPhase = (state == SEQ_FINAL);
    ctl.capture    = (state == SEQ_STROBE) && (waitCnt == '0) && !curWrite;
  end

endmodule

// File: rtl/xmem_bus_dp.sv
module xmem_bus_dp
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqCtl_t                  ctl,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [ADDR_W-DATA_W-1:0] sectorLimit,
  input  logic [WAIT_W-1:0]        waitLow,
  input  logic [WAIT_W-1:0]        waitHigh,
  input  logic                     keeperEn,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     curWrite,
  output logic [WAIT_W-1:0]        curWait,
  output logic [DATA_W-1:0]        rdData,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] addrLoReg;
  logic [DATA_W-1:0] busData;
  logic              upperSector;
  logic [WAIT_W-1:0] waitPick;

  assign upperSector = (reqAddr[ADDR_W-1 -: HI_W] >= sectorLimit);
  assign waitPick    = upperSector ? waitHigh : waitLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoReg <= '0;
      addrHi    <= '0;
      curWrite  <= 1'b0;
      curWait   <= '0;
      busData   <= '0;
      rdData    <= '0;
    end else begin
      if (ctl.accept) begin
        addrLoReg <= reqAddr[DATA_W-1:0];
        addrHi    <= reqAddr[ADDR_W-1 -: HI_W];
        curWrite  <= reqWrite;
        curWait   <= waitPick;
        if (reqWrite) busData <= reqWdata;
      end
      if (ctl.capture) begin
        busData <= adIn;
        rdData  <= adIn;
      end
    end
  end

  always_comb begin
    ale   = ctl.addrPhase;
    rdN   = !(ctl.strbPhase && !curWrite);
    wrN   = !(ctl.strbPhase && curWrite);
    adOut = ctl.addrPhase ? addrLoReg : busData;
    adOe  = ctl.addrPhase
          | (curWrite && (ctl.strbPhase || ctl.finalPhase))
          | (ctl.idle && keeperEn);
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coreValidI,
  input  logic                     coreWriteI,
  input  logic [ADDR_W-1:0]        coreAddrI,
  input  logic [DATA_W-1:0]        coreWdataI,
  output logic                     coreReadyO,
  output logic [DATA_W-1:0]        coreRdataO,
  input  logic [ADDR_W-DATA_W-1:0] cfgSectorLimitI,
  input  logic [WAIT_W-1:0]        cfgWaitLowI,
  input  logic [WAIT_W-1:0]        cfgWaitHighI,
  input  logic                     cfgKeeperI,
  output logic                     memAleO,
  output logic                     memRdNO,
  output logic                     memWrNO,
  output logic [ADDR_W-DATA_W-1:0] memAddrHiO,
  output logic [DATA_W-1:0]        memAdO,
  output logic                     memAdOeO,
  input  logic [DATA_W-1:0]        memAdI
);

  seqCtl_t           ctl;
  logic              curWrite;
  logic [WAIT_W-1:0] curWait;

  xmem_seq_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (coreValidI),
    .curWrite (curWrite),
    .curWait  (curWait),
    .ctl      (ctl)
  );

  xmem_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqWrite    (coreWriteI),
    .reqAddr     (coreAddrI),
    .reqWdata    (coreWdataI),
    .sectorLimit (cfgSectorLimitI),
    .waitLow     (cfgWaitLowI),
    .waitHigh    (cfgWaitHighI),
    .keeperEn    (cfgKeeperI),
    .adIn        (memAdI),
    .curWrite    (curWrite),
    .curWait     (curWait),
    .rdData      (coreRdataO),
    .ale         (memAleO),
    .rdN         (memRdNO),
    .wrN         (memWrNO),
    .addrHi      (memAddrHiO),
    .adOut       (memAdO),
    .adOe        (memAdOeO)
  );

  assign coreReadyO = ctl.finalPhase;

endmodule

// File: rtl/xmem_bus_chk.sv
module xmem_bus_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            ale,
  input logic            rdN,
  input logic            wrN,
  input logic            ready,
  input logic            adOe,
  input logic [HI_W-1:0] addrHi
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R7

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN)); // R7

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R2

  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (!rdN || !wrN)); // R4

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready); // R8

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ($past(!rdN || !wrN) && rdN && wrN)); // R8

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ale |-> $stable(addrHi)); // R10

  AST_WR_DRIVES_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe); // R5

  AST_RD_RELEASES_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R6

endmodule

bind xmem_bus_ctrl xmem_bus_chk #(.HI_W(ADDR_W-DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .ale    (memAleO),
  .rdN    (memRdNO),
  .wrN    (memWrNO),
  .ready  (coreReadyO),
  .adOe   (memAdOeO),
  .addrHi (memAddrHiO)
);

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreValidI = 1'b0;
  logic        coreWriteI = 1'b0;
  logic [15:0] coreAddrI = '0;
  logic [7:0]  coreWdataI = '0;
  logic        coreReadyO;
  logic [7:0]  coreRdataO;
  logic [7:0]  cfgSectorLimitI = 8'h80;
  logic [1:0]  cfgWaitLowI = 2'd0;
  logic [1:0]  cfgWaitHighI = 2'd0;
  logic        cfgKeeperI = 1'b0;
  logic        memAleO, memRdNO, memWrNO, memAdOeO;
  logic [7:0]  memAddrHiO, memAdO;
  logic [7:0]  memAdI = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xmem_bus_ctrl u0 (
    .clk(clk), .rstN(rstN),
    .coreValidI(coreValidI), .coreWriteI(coreWriteI), .coreAddrI(coreAddrI),
    .coreWdataI(coreWdataI), .coreReadyO(coreReadyO), .coreRdataO(coreRdataO),
    .cfgSectorLimitI(cfgSectorLimitI), .cfgWaitLowI(cfgWaitLowI),
    .cfgWaitHighI(cfgWaitHighI), .cfgKeeperI(cfgKeeperI),
    .memAleO(memAleO), .memRdNO(memRdNO), .memWrNO(memWrNO),
    .memAddrHiO(memAddrHiO), .memAdO(memAdO), .memAdOeO(memAdOeO), .memAdI(memAdI)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One complete access; checks every period of the cycle.
  task automatic runAccess(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] rdRet, input int expWait, input bit chgCfg);
    int total;
    total = 3 + expWait;
    @(negedge clk);
    coreValidI = 1'b1; coreWriteI = wr; coreAddrI = addr; coreWdataI = wd; memAdI = rdRet;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(memAleO == 1'b1, "R2 ale in address period", memAleO, 1);
        chk(memAdOeO && memAdO == addr[7:0], "R2 low address on port", memAdO, addr[7:0]);
        chk(memAddrHiO == addr[15:8], "R2 high address", memAddrHiO, addr[15:8]);
        chk(memRdNO && memWrNO, "R7 no strobe with ale", {memRdNO, memWrNO}, 3);
        if (chgCfg) begin
          cfgWaitLowI  = ~cfgWaitLowI;
          cfgWaitHighI = ~cfgWaitHighI;
        end
      end else if (k < total) begin
        chk(memAleO == 1'b0, "R9 ale low in strobe", memAleO, 0);
        chk(coreReadyO == 1'b0, "R8 no ready early", coreReadyO, 0);
        if (wr) begin
          chk(memWrNO == 1'b0 && memRdNO, "R5 write strobe / R4 length", {memRdNO, memWrNO}, 2);
          chk(memAdOeO && memAdO == wd, "R5 write data on port", memAdO, wd);
        end else begin
          chk(memRdNO == 1'b0 && memWrNO, "R6 read strobe / R4 length", {memRdNO, memWrNO}, 1);
          chk(memAdOeO == 1'b0, "R6 port released", memAdOeO, 0);
        end
      end else begin
        chk(memRdNO && memWrNO, "R4 strobe ends on time (R3 sector)", {memRdNO, memWrNO}, 3);
        chk(coreReadyO == 1'b1, "R8 ready in final period", coreReadyO, 1);
        if (wr) chk(memAdOeO && memAdO == wd, "R5 write data held", memAdO, wd);
        else    chk(coreRdataO == rdRet, "R6 read data with ready", coreRdataO, rdRet);
        coreValidI = 1'b0;
        memAdI = 8'h00;
      end
    end
    @(negedge clk);
    chk(coreReadyO == 1'b0, "R8 ready single period", coreReadyO, 0);
    chk(memAleO == 1'b0, "R9 no ale while idle", memAleO, 0);
    chk(memAddrHiO == addr[15:8], "R10 high address held", memAddrHiO, addr[15:8]);
    if (cfgKeeperI) begin
      chk(memAdOeO == 1'b1, "R11 keeper drives port", memAdOeO, 1);
      chk(memAdO == (wr ? wd : rdRet), "R11 keeper holds last data", memAdO, wr ? wd : rdRet);
    end else begin
      chk(memAdOeO == 1'b0, "R11 port released without keeper", memAdOeO, 0);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(memAleO == 0 && memRdNO && memWrNO, "R1 strobes idle in reset", {memAleO, memRdNO, memWrNO}, 3);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(coreReadyO == 0, "R1 ready low", coreReadyO, 0);
    chk(memAddrHiO == 8'h00, "R1 high address zero", memAddrHiO, 0);
    chk(memAdOeO == 0, "R1 port released", memAdOeO, 0);
    chk(memAleO == 0, "R1 ale low", memAleO, 0);
  endtask

  task automatic testAllWaits();
    // lower sector (limit 0x80), every wait setting, writes then reads
    for (int w = 0; w < 4; w++) begin
      cfgWaitLowI = 2'(w);
      runAccess(1'b1, 16'h1234 + 16'(w), 8'hA0 + 8'(w), 8'h00, w, 1'b0); // R4
      runAccess(1'b0, 16'h2200 + 16'(w), 8'h00, 8'h5C ^ 8'(w), w, 1'b0); // R6
    end
  endtask

  task automatic testSectors();
    cfgSectorLimitI = 8'h80; cfgWaitLowI = 2'd1; cfgWaitHighI = 2'd3;
    runAccess(1'b0, 16'h8000, 8'h00, 8'hC3, 3, 1'b0); // R3 at threshold -> upper
    runAccess(1'b1, 16'h7FFF, 8'h3C, 8'h00, 1, 1'b0); // R3 just below -> lower
    runAccess(1'b1, 16'hFF01, 8'h99, 8'h00, 3, 1'b0); // R3 top of space
    cfgSectorLimitI = 8'h00;
    runAccess(1'b0, 16'h0010, 8'h00, 8'h42, 3, 1'b0); // R3 limit zero -> all upper
    cfgSectorLimitI = 8'h80;
  endtask

  task automatic testKeeper();
    cfgKeeperI = 1'b1; cfgWaitLowI = 2'd0;
    runAccess(1'b1, 16'h0405, 8'h6E, 8'h00, 0, 1'b0); // R11 write then hold
    runAccess(1'b0, 16'h0506, 8'h00, 8'hB7, 0, 1'b0); // R11 read then hold
    repeat (3) @(negedge clk);
    chk(memAdOeO && memAdO == 8'hB7, "R11 keeper steady over idle", memAdO, 8'hB7);
    chk(memAleO == 0, "R9 no ale over long idle", memAleO, 0);
    cfgKeeperI = 1'b0;
    @(negedge clk);
    chk(memAdOeO == 0, "R11 keeper off releases", memAdOeO, 0);
  endtask

  task automatic testCfgChange();
    cfgWaitLowI = 2'd2; cfgWaitHighI = 2'd1;
    runAccess(1'b1, 16'h0100, 8'h17, 8'h00, 2, 1'b1); // R12 low sector, cfg flipped to 1
    cfgWaitLowI = 2'd2; cfgWaitHighI = 2'd1;
    runAccess(1'b0, 16'hC000, 8'h00, 8'hE4, 1, 1'b1); // R12 high sector, cfg flipped to 2
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    testReset();
    testAllWaits();
    testSectors();
    testKeeper();
    testCfgChange();
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      report();
    end
  end

endmodule